// File: doc/BRIEF.md
# Quadrature Encoder Position Counter with Qualified Index Reset

The block turns the two channels of an incremental encoder into a wrapping position count and a direction bit. It supports full x4 quadrature decoding and two clock-style modes: one clock line with a direction line, and separate up and down clock lines. The counter counts from 0 up to a programmable reload value and wraps at either end. Each wrap raises a one-cycle update pulse.

An index input can clear the count to zero. The clear happens only when several conditions hold together. The feature must be enabled. The count direction must pass a latched qualifier. A selected auxiliary input must not be blanking the index. The encoder lines must be in the programmed position state. In one-shot mode, the clear must not have happened already. Every clear sets a sticky flag, which the host clears by writing one.

Top module: `qenc_index_ctr`

## Requirements
- R1: In quadrature mode (mode 0), the {A,B} sequence 00→01→11→10→00 counts up and the reverse sequence counts down. There is one count per legal transition. dir_o is 0 after an up step and 1 after a down step.
- R2: In quadrature mode, a transition in which A and B both change leaves the count unchanged and sets err_o. err_o stays set until reset.
- R3: Counting up from the reload value gives 0. Counting down from 0 gives the reload value. Each wrap gives exactly one update_o pulse.
- R4: While idx_en_i is 0, the index never clears the count and never sets idx_flag_o.
- R5: The direction qualifier works as follows: 0 clears in either direction, 1 clears only when the effective direction is up, and 2 clears only when it is down. The qualifier is captured only while idx_en_i is 0. Changes made while idx_en_i is 1 have no effect.
- R6: The blanking select works as follows: 0 means no blanking, 1 suppresses the index while aux3 is active, and 2 suppresses it while aux4 is active. An aux input is active when its level differs from its polarity bit, so polarity 0 means active high.
- R7: With idx_first_i at 1, only the first qualified index clears the count. Clearing idx_first_i re-arms the one-shot.
- R8: In quadrature mode, a clear happens only when {A,B} equals idx_pos_i, with bit 1 being A.
- R9: In clock-plus-direction mode (mode 1), each rising edge of A counts one step. The step is down when B is 1. A clear requires A to equal idx_pos_i[0], and idx_pos_i[1] is ignored.
- R10: In bidirectional clock mode (mode 2), a rising edge of A counts up and a rising edge of B counts down. A clear requires both A and B to equal idx_pos_i[0].
- R11: A qualified index loads 0 on the next edge, and this takes priority over a simultaneous step. The clear also sets idx_flag_o. A one-cycle pulse on idx_flag_clr_i clears idx_flag_o.
- R12: After reset, count_o, dir_o, update_o, idx_flag_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 quadrature, 1 clock+direction, 2 bidirectional clock |
| enc_a_i | input | 1 | Encoder channel A / clock |
| enc_b_i | input | 1 | Encoder channel B / direction / down clock |
| index_i | input | 1 | Index pulse |
| aux3_i | input | 1 | First blanking input |
| aux4_i | input | 1 | Second blanking input |
| aux3_pol_i | input | 1 | aux3 polarity, 0 active high |
| aux4_pol_i | input | 1 | aux4 polarity, 0 active high |
| idx_en_i | input | 1 | Index clear enable |
| idx_dir_i | input | 2 | Direction qualifier |
| idx_blank_i | input | 2 | Blanking source select |
| idx_first_i | input | 1 | One-shot index mode |
| idx_pos_i | input | 2 | Position state / clock level for clear |
| reload_i | input | CNT_W | Wrap value |
| idx_flag_clr_i | input | 1 | Write-one-to-clear for idx_flag_o |
| count_o | output | CNT_W | Position count |
| dir_o | output | 1 | Last count direction, 1 down |
| update_o | output | 1 | One-cycle wrap pulse |
| idx_flag_o | output | 1 | Sticky index-clear flag |
| err_o | output | 1 | Sticky illegal quadrature jump flag |

## Verification
The bench builds the block with CNT_W at 8 and SYNC_STAGES at 2. With a reload value of 5, both wrap directions occur within a few encoder steps. The two-stage synchronizer fixes the latency from a pin change to the count at three edges. The bench therefore waits a fixed settling interval after each stimulus. Index scenarios move the encoder into the programmed state while the index is held high. This exercises the case where a clear and a step coincide, across all three modes.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD   = 2'd0,
    MODE_CLKDIR = 2'd1,
    MODE_BIDIR  = 2'd2,
    MODE_OFF    = 2'd3
  } qenc_mode_e;

  typedef enum logic [1:0] {
    DQ_ANY  = 2'd0,
    DQ_UP   = 2'd1,
    DQ_DOWN = 2'd2,
    DQ_RSVD = 2'd3
  } dir_qual_e;

  typedef enum logic [1:0] {
    BL_NONE = 2'd0,
    BL_AUX3 = 2'd1,
    BL_AUX4 = 2'd2,
    BL_RSVD = 2'd3
  } blank_sel_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       step_o,
  output logic       down_o,
  output logic       err_o
);
  logic       pa_q, pb_q, err_q;
  logic [1:0] cur, prv;
  logic       fwd, bwd, illegal, rise_a, rise_b;
  qenc_mode_e mode;

  assign mode    = qenc_mode_e'(mode_i);
  assign cur     = {a_i, b_i};
  assign prv     = {pa_q, pb_q};
  assign fwd     = (cur == {prv[0], ~prv[1]});
  assign bwd     = (cur == {~prv[0], prv[1]});
  assign illegal = (mode == MODE_QUAD) && ((cur ^ prv) == 2'b11);
  assign rise_a  = a_i & ~pa_q;
  assign rise_b  = b_i & ~pb_q;

  always_comb begin
    step_o = 1'b0;
    down_o = 1'b0;
    unique case (mode)
      MODE_QUAD: begin
        step_o = fwd | bwd;
        down_o = bwd;
      end
      MODE_CLKDIR: begin
        step_o = rise_a;
        down_o = b_i;
      end
      MODE_BIDIR: begin
        step_o = rise_a ^ rise_b;
        down_o = rise_b;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      pa_q  <= a_i;
      pb_q  <= b_i;
      if (illegal) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  AST_JUMP_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |-> !step_o); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R2
endmodule

// File: rtl/qenc_index_qual.sv
module qenc_index_qual
  import qenc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       idx_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       aux3_i,
  input  logic       aux4_i,
  input  logic       aux3_pol_i,
  input  logic       aux4_pol_i,
  input  logic       dir_down_i,
  input  logic       en_i,
  input  logic [1:0] dir_sel_i,
  input  logic [1:0] blank_i,
  input  logic       first_i,
  input  logic [1:0] pos_i,
  output logic       hit_o
);
  logic      armed_q;
  dir_qual_e dir_sel_q;
  logic      pos_ok, dir_ok, blanked;

  always_comb begin
    unique case (qenc_mode_e'(mode_i))
      MODE_QUAD:   pos_ok = ({a_i, b_i} == pos_i);
      MODE_CLKDIR: pos_ok = (a_i == pos_i[0]);
      MODE_BIDIR:  pos_ok = (a_i == pos_i[0]) && (b_i == pos_i[0]);
      default:     pos_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (dir_sel_q)
      DQ_UP:   dir_ok = !dir_down_i;
      DQ_DOWN: dir_ok = dir_down_i;
      default: dir_ok = 1'b1;
    endcase
  end

  always_comb begin
    unique case (blank_sel_e'(blank_i))
      BL_AUX3: blanked = aux3_i ^ aux3_pol_i;
      BL_AUX4: blanked = aux4_i ^ aux4_pol_i;
      default: blanked = 1'b0;
    endcase
  end

  assign hit_o = en_i && idx_i && pos_ok && dir_ok && !blanked && (!first_i || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_sel_q <= DQ_ANY;
      armed_q   <= 1'b1;
    end else begin
      if (!en_i)        dir_sel_q <= dir_qual_e'(dir_sel_i);
      if (!first_i)     armed_q   <= 1'b1;
      else if (hit_o)   armed_q   <= 1'b0;
    end
  end

  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o); // R4
  AST_DIR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> $stable(dir_sel_q)); // R5
  AST_FIRST_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i && $past(first_i) && $past(hit_o)) |-> !hit_o); // R7
endmodule

// File: rtl/qenc_index_ctr.sv
module qenc_index_ctr
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic             index_i,
  input  logic             aux3_i,
  input  logic             aux4_i,
  input  logic             aux3_pol_i,
  input  logic             aux4_pol_i,
  input  logic             idx_en_i,
  input  logic [1:0]       idx_dir_i,
  input  logic [1:0]       idx_blank_i,
  input  logic             idx_first_i,
  input  logic [1:0]       idx_pos_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             idx_flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             update_o,
  output logic             idx_flag_o,
  output logic             err_o
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] raw, syn;
  logic              a_s, b_s, aux3_s, aux4_s, idx_s;
  logic              step, step_down, dir_eff, hit;
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q, upd_q, flag_q;

  assign raw = {index_i, aux4_i, aux3_i, enc_b_i, enc_a_i};
  assign {idx_s, aux4_s, aux3_s, b_s, a_s} = syn;

  qenc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw), .q_o (syn)
  );

  qenc_decode u_dec (
    .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i),
    .a_i (a_s), .b_i (b_s),
    .step_o (step), .down_o (step_down), .err_o (err_o)
  );

  // direction seen by the qualifier: current step if any, else last one
  assign dir_eff = step ? step_down : dir_q;

  qenc_index_qual u_qual (
    .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i),
    .idx_i (idx_s), .a_i (a_s), .b_i (b_s),
    .aux3_i (aux3_s), .aux4_i (aux4_s),
    .aux3_pol_i (aux3_pol_i), .aux4_pol_i (aux4_pol_i),
    .dir_down_i (dir_eff), .en_i (idx_en_i), .dir_sel_i (idx_dir_i),
    .blank_i (idx_blank_i), .first_i (idx_first_i), .pos_i (idx_pos_i),
    .hit_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      upd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (step) dir_q <= step_down;
      if (hit) begin
        cnt_q <= '0;
      end else if (step && !step_down) begin
        if (cnt_q == reload_i) begin
          cnt_q <= '0;
          upd_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (step) begin
        if (cnt_q == '0) begin
          cnt_q <= reload_i;
          upd_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (hit)                 flag_q <= 1'b1;
      else if (idx_flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign count_o    = cnt_q;
  assign dir_o      = dir_q;
  assign update_o   = upd_q;
  assign idx_flag_o = flag_q;

  AST_IDX_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (count_o == '0)); // R11
  AST_IDX_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> idx_flag_o); // R11
  AST_UPD_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (count_o == '0 || count_o == $past(reload_i))); // R3
endmodule

// File: tb/qenc_index_ctr_tb_top.sv
module qenc_index_ctr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0, idx_dir = 2'd0, idx_blank = 2'd0, idx_pos = 2'd0;
  logic a = 0, b = 0, idx = 0, aux3 = 0, aux4 = 0, aux3_pol = 0, aux4_pol = 0;
  logic idx_en = 0, idx_first = 0, clr = 0;
  logic [CNT_W-1:0] reload = 8'd200;
  logic [CNT_W-1:0] count;
  logic dir, upd, flag, err;
  int checks = 0, errors = 0, upd_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_index_ctr #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode),
    .enc_a_i (a), .enc_b_i (b), .index_i (idx),
    .aux3_i (aux3), .aux4_i (aux4), .aux3_pol_i (aux3_pol), .aux4_pol_i (aux4_pol),
    .idx_en_i (idx_en), .idx_dir_i (idx_dir), .idx_blank_i (idx_blank),
    .idx_first_i (idx_first), .idx_pos_i (idx_pos), .reload_i (reload),
    .idx_flag_clr_i (clr), .count_o (count), .dir_o (dir), .update_o (upd),
    .idx_flag_o (flag), .err_o (err)
  );

  always @(negedge clk) if (rst_n && upd) upd_seen++;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic move(input logic na, input logic nb);
    @(negedge clk); a = na; b = nb;
    settle();
  endtask

  task automatic set_idx(input logic v);
    @(negedge clk); idx = v;
    settle();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(count, 0, "R12 count"); chk(dir, 0, "R12 dir"); chk(upd, 0, "R12 update");
    chk(flag, 0, "R12 flag"); chk(err, 0, "R12 err");
    rst_n = 1;
    settle();
    chk(count, 0, "R12 count after release");
  endtask

  task automatic t_quad();
    move(0,1); move(1,1); move(1,0); move(0,0);
    chk(count, 4, "R1 up count"); chk(dir, 0, "R1 up dir");
    move(1,0);
    chk(count, 3, "R1 down count"); chk(dir, 1, "R1 down dir");
  endtask

  task automatic t_illegal();
    move(0,1);
    chk(count, 3, "R2 jump ignored"); chk(err, 1, "R2 err set");
    move(1,1);
    chk(count, 4, "R2 legal after jump"); chk(err, 1, "R2 err sticky");
  endtask

  task automatic t_wrap();
    int u0;
    reload = 8'd5;
    move(1,0);
    chk(count, 5, "R3 at reload");
    u0 = upd_seen;
    move(0,0);
    chk(count, 0, "R3 wrap up"); chk(upd_seen - u0, 1, "R3 update up");
    move(1,0);
    chk(count, 5, "R3 wrap down"); chk(upd_seen - u0, 2, "R3 update down");
  endtask

  task automatic t_idx_off();
    idx_en = 0; idx_pos = 2'b10;
    set_idx(1);
    chk(count, 5, "R4 disabled no clear"); chk(flag, 0, "R4 disabled no flag");
    set_idx(0);
  endtask

  task automatic t_pos_prio();
    idx_dir = 2'd0; settle();
    idx_en = 1; idx_pos = 2'b11;
    set_idx(1);
    chk(count, 5, "R8 wrong state no clear");
    move(1,1);
    chk(count, 0, "R11 clear beats step"); chk(flag, 1, "R11 flag set");
    set_idx(0);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    settle();
    chk(flag, 0, "R11 flag cleared");
  endtask

  task automatic t_dirq();
    idx_en = 0; idx_dir = 2'd2; settle(); idx_en = 1;
    idx_pos = 2'b10;
    set_idx(1);
    move(1,0);
    chk(count, 1, "R5 down-only ignores up");
    move(1,1); move(1,0);
    chk(count, 1, "R5 down-only after return");
    @(negedge clk); idx_dir = 2'd1; settle();
    chk(count, 1, "R5 qualifier locked while enabled");
    set_idx(0);
  endtask

  task automatic t_blank();
    idx_en = 0; idx_dir = 2'd0; settle(); idx_en = 1;
    idx_pos = 2'b10; idx_blank = 2'd1; aux3_pol = 0; aux3 = 1;
    set_idx(1);
    chk(count, 1, "R6 aux3 blanks");
    @(negedge clk); aux3 = 0; settle();
    chk(count, 0, "R6 aux3 released");
    set_idx(0);
    move(0,0);
    idx_pos = 2'b00; idx_blank = 2'd2; aux4_pol = 1; aux4 = 0;
    set_idx(1);
    chk(count, 1, "R6 aux4 active low blanks");
    @(negedge clk); aux4 = 1; settle();
    chk(count, 0, "R6 aux4 released");
    set_idx(0);
    idx_blank = 2'd0;
  endtask

  task automatic t_first();
    idx_first = 1; idx_pos = 2'b00;
    move(0,1); move(1,1); move(1,0); move(0,0);
    set_idx(1);
    chk(count, 0, "R7 first index clears");
    set_idx(0);
    move(0,1); move(1,1); move(1,0); move(0,0);
    set_idx(1);
    chk(count, 4, "R7 second index ignored");
    set_idx(0);
    @(negedge clk); idx_first = 0; settle();
    set_idx(1);
    chk(count, 0, "R7 re-armed");
    set_idx(0);
  endtask

  task automatic t_clkdir();
    @(negedge clk); mode = 2'd1; settle();
    for (int i = 0; i < 3; i++) begin move(1,0); move(0,0); end
    chk(count, 3, "R9 up pulses");
    move(0,1); move(1,1); move(0,1);
    chk(count, 2, "R9 down pulse"); chk(dir, 1, "R9 dir down");
    idx_pos = 2'b01;
    set_idx(1);
    chk(count, 2, "R9 wrong level no clear");
    move(1,1);
    chk(count, 0, "R9 clear at high level");
    set_idx(0);
    move(0,1); move(0,0);
    idx_pos = 2'b10;
    move(1,0); move(0,0); move(1,0); move(0,0);
    chk(count, 2, "R9 count before low-level clear");
    set_idx(1);
    chk(count, 0, "R9 bit1 ignored, low level clears");
    set_idx(0);
  endtask

  task automatic t_bidir();
    @(negedge clk); mode = 2'd2; settle();
    move(1,0); move(0,0); move(1,0); move(0,0);
    chk(count, 2, "R10 up clock");
    move(0,1); move(0,0);
    chk(count, 1, "R10 down clock"); chk(dir, 1, "R10 dir down");
    idx_pos = 2'b01;
    set_idx(1);
    move(1,0);
    chk(count, 2, "R10 one line high no clear");
    move(1,1);
    chk(count, 0, "R10 both high clears");
    set_idx(0);
    move(0,0);
    chk(count, 0, "R10 falling edges no count");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_quad();
    t_illegal();
    t_wrap();
    t_idx_off();
    t_pos_prio();
    t_dirq();
    t_blank();
    t_first();
    t_clkdir();
    t_bidir();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule